// File: doc/BRIEF.md
# Two-Wire Alternating-Strobe Packet Transmitter

This block serialises a packet of 32-bit words onto a self-clocked bus of two wires, A and B. Neither wire is a dedicated clock. On every bit one wire is the strobe and the other carries the data. The roles swap from one bit to the next, so a receiver takes the data level from whichever wire did not fall.

A packet opens with a fixed start pattern and closes with a fixed end pattern. Both patterns are timed by a unit delay counted in system clock cycles. Between them come the data bytes, followed by one XOR check byte. Words enter through a valid/ready port. The first word carries the packet length as a count minus one. A one-word staging register lets the next word arrive while the current one is still being shifted out. The block drives both wires only while a packet is in flight. At all other times it drops the output enables so that pull-ups hold the bus high.

Top module: `alt_phase_tx`

## Requirements
- R1: After reset, and whenever no packet is in flight, `busy_o` is 0, both output enables are 0 and `word_ready_o` is 1.
- R2: The start pattern is, as (A,B) levels with their durations in cycles, with U = UNIT_CYC: (1,1) for U, (0,1) for U, then (0,0) for U and (0,1) for U repeated four times, then (1,1) for 1 cycle, then (1,0) for U.
- R3: Data bits alternate between two phases, and the first bit of the packet uses phase one. In phase one, A is high with B equal to the bit for S = PHASE_CYC/2 cycles, then A is low with B held for PHASE_CYC−S cycles. Phase two is the same with the roles of A and B exchanged.
- R4: Each byte is sent most significant bit first. Each word is sent as four bytes, starting with bits 7:0 and ending with bits 31:24.
- R5: After the last data byte, one check byte is sent in the same bit format. It equals the XOR of all data bytes of the packet.
- R6: The end pattern follows the last bit of the check byte. With H = UNIT_CYC/2 and k the A level during that last bit, it is: (k,1) for H, (k,0) for H, (0,0) for U, (1,0) for U, (0,0) for U, (1,0) for U, (1,1) for U.
- R7: Both output enables rise in the cycle after the handshake that accepts the first word. They stay high through the last end-pattern cycle and are low in the following cycle.
- R8: `busy_o` is high exactly while the outputs are enabled. While busy, `word_ready_o` is 0 once the packet's words have all been accepted. A word offered while busy after that is ignored and does not start a new packet.
- R9: The packet carries exactly `len_m1_i`+1 words, where `len_m1_i` is sampled with the first word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| word_valid_i | input | 1 | Input word valid |
| word_data_i | input | 32 | Input word |
| len_m1_i | input | LEN_W | Word count minus one, sampled with the first word |
| word_ready_o | output | 1 | Block can accept a word |
| busy_o | output | 1 | Packet in flight |
| wire_a_o | output | 1 | Level driven on wire A |
| wire_a_oe_o | output | 1 | Output enable for wire A |
| wire_b_o | output | 1 | Level driven on wire B |
| wire_b_oe_o | output | 1 | Output enable for wire B |

## Verification
Most wrong internal states show up on the wires within a single phase. A phase counter off by one stretches or shortens one level by a cycle. A wrong byte index, bit order or phase parity swaps a data level, or puts it on the wrong wire within PHASE_CYC cycles. A corrupted check accumulator stays hidden until the check byte, and then shows in its first wrong bit. A pattern step counter fault shows within one unit delay. A state that fails to return to idle keeps the enables high one cycle too long. The bench compares every enabled cycle against a waveform it builds on its own from the packet contents.

// File: rtl/alt_phase_pkg.sv
package alt_phase_pkg;

  typedef enum logic [1:0] {TX_IDLE, TX_START, TX_DATA, TX_END} tx_state_e;

  localparam int START_STEPS = 12;
  localparam int END_STEPS   = 7;

  // byte idx of a word, idx 0 = bits 7:0
  function automatic logic [7:0] byte_of(input logic [31:0] w, input logic [1:0] idx);
    return w[8*idx +: 8];
  endfunction

  // {A,B} level of a start-pattern step
  function automatic logic [1:0] start_lvl(input logic [3:0] s);
    case (s)
      4'd0:    return 2'b11;
      4'd1:    return 2'b01;
      4'd10:   return 2'b11;
      4'd11:   return 2'b10;
      default: return s[0] ? 2'b01 : 2'b00;
    endcase
  endfunction

  // {A,B} level of an end-pattern step; keep = A level carried from last bit
  function automatic logic [1:0] end_lvl(input logic [3:0] s, input logic keep);
    case (s)
      4'd0:    return {keep, 1'b1};
      4'd1:    return {keep, 1'b0};
      4'd2:    return 2'b00;
      4'd3:    return 2'b10;
      4'd4:    return 2'b00;
      4'd5:    return 2'b10;
      default: return 2'b11;
    endcase
  endfunction

  // length of a pattern step in cycles
  function automatic int step_len(input logic is_end, input logic [3:0] s,
                                  input int unit, input int half);
    if (!is_end) return (s == 4'd10) ? 1 : unit;
    return (s <= 4'd1) ? half : unit;
  endfunction

endpackage

// File: rtl/alt_phase_pattern.sv
module alt_phase_pattern
  import alt_phase_pkg::*;
#(
  parameter int UNIT_CYC = 125
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic go_i,
  input  logic sel_end_i,
  input  logic keep_a_i,
  output logic active_o,
  output logic last_o,
  output logic a_o,
  output logic b_o
);
  localparam int HALF_CYC = (UNIT_CYC / 2 < 1) ? 1 : UNIT_CYC / 2;
  localparam int CNT_W    = $clog2(UNIT_CYC + 1);

  logic             active_q, sel_q, keep_q;
  logic [3:0]       step_q;
  logic [CNT_W-1:0] cnt_q;
  logic [3:0]       last_step;
  logic [1:0]       lvl;

  assign last_step = sel_q ? 4'(END_STEPS - 1) : 4'(START_STEPS - 1);
  assign last_o    = active_q && (cnt_q == '0) && (step_q == last_step);
  assign active_o  = active_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      sel_q    <= 1'b0;
      keep_q   <= 1'b1;
      step_q   <= '0;
      cnt_q    <= '0;
    end else if (go_i) begin
      active_q <= 1'b1;
      sel_q    <= sel_end_i;
      keep_q   <= keep_a_i;
      step_q   <= '0;
      cnt_q    <= CNT_W'(step_len(sel_end_i, 4'd0, UNIT_CYC, HALF_CYC) - 1);
    end else if (active_q) begin
      if (cnt_q == '0) begin
        if (step_q == last_step) begin
          active_q <= 1'b0;
        end else begin
          step_q <= step_q + 4'd1;
          cnt_q  <= CNT_W'(step_len(sel_q, step_q + 4'd1, UNIT_CYC, HALF_CYC) - 1);
        end
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  always_comb begin
    if (!active_q)  lvl = 2'b11;
    else if (sel_q) lvl = end_lvl(step_q, keep_q);
    else            lvl = start_lvl(step_q);
  end
  assign a_o = lvl[1];
  assign b_o = lvl[0];

  AST_PAT_STEP_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q |-> step_q <= last_step); // R6

endmodule

// File: rtl/alt_phase_shift.sv
module alt_phase_shift #(
  parameter int PHASE_CYC = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       load_i,
  input  logic [7:0] byte_i,
  output logic       active_o,
  output logic       done_o,
  output logic       a_o,
  output logic       b_o
);
  localparam int SETUP_CYC = PHASE_CYC / 2;
  localparam int PC_W      = (PHASE_CYC > 1) ? $clog2(PHASE_CYC) : 1;

  logic            active_q;
  logic [7:0]      shreg_q;
  logic [2:0]      bitn_q;
  logic [PC_W-1:0] cyc_q;
  logic            strobe_hi, data_bit, phase_two, phase_end;

  assign phase_end = (cyc_q == PC_W'(PHASE_CYC - 1));
  assign done_o    = active_q && phase_end && (bitn_q == 3'd7);
  assign active_o  = active_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      shreg_q  <= '0;
      bitn_q   <= '0;
      cyc_q    <= PC_W'(PHASE_CYC - 1);
    end else if (load_i) begin
      active_q <= 1'b1;
      shreg_q  <= byte_i;
      bitn_q   <= '0;
      cyc_q    <= '0;
    end else if (active_q) begin
      if (phase_end) begin
        if (bitn_q == 3'd7) begin
          active_q <= 1'b0;          // freeze: outputs hold last levels
        end else begin
          bitn_q  <= bitn_q + 3'd1;
          shreg_q <= {shreg_q[6:0], 1'b0};
          cyc_q   <= '0;
        end
      end else begin
        cyc_q <= cyc_q + 1'b1;
      end
    end
  end

  assign strobe_hi = (cyc_q < PC_W'(SETUP_CYC));
  assign data_bit  = shreg_q[7];
  assign phase_two = bitn_q[0];
  assign a_o = phase_two ? data_bit  : strobe_hi;
  assign b_o = phase_two ? strobe_hi : data_bit;

  AST_DATA_HELD_AT_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && $fell(strobe_hi)) |-> $stable(data_bit)); // R3

endmodule

// File: rtl/alt_phase_tx.sv
module alt_phase_tx
  import alt_phase_pkg::*;
#(
  parameter int LEN_W     = 8,
  parameter int UNIT_CYC  = 125,
  parameter int PHASE_CYC = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             word_valid_i,
  input  logic [31:0]      word_data_i,
  input  logic [LEN_W-1:0] len_m1_i,
  output logic             word_ready_o,
  output logic             busy_o,
  output logic             wire_a_o,
  output logic             wire_a_oe_o,
  output logic             wire_b_o,
  output logic             wire_b_oe_o
);
  tx_state_e        state_q;
  logic [31:0]      stage_q, cur_q;
  logic             stage_full_q, wait_word_q, sending_chk_q;
  logic [LEN_W-1:0] acc_left_q, send_left_q;
  logic [1:0]       byte_idx_q;
  logic [7:0]       chk_q;

  // named internal events
  logic word_fire, pkt_open, start_done, word_boundary, need_word, load_word;
  logic next_byte, load_chk, end_go, ser_load;
  logic [7:0] ser_byte;
  logic pat_active, pat_last, pat_a, pat_b;
  logic ser_active, ser_done, ser_a, ser_b;

  assign word_ready_o = (state_q == TX_IDLE) ||
                        (((state_q == TX_START) || (state_q == TX_DATA)) &&
                         !stage_full_q && (acc_left_q != '0));
  assign word_fire     = word_valid_i && word_ready_o;
  assign pkt_open      = (state_q == TX_IDLE) && word_fire;
  assign start_done    = (state_q == TX_START) && pat_last;
  assign word_boundary = (state_q == TX_DATA) && ser_done && !sending_chk_q && (byte_idx_q == 2'd3);
  assign need_word     = start_done || (word_boundary && (send_left_q != '0)) || wait_word_q;
  assign load_word     = need_word && stage_full_q;
  assign next_byte     = (state_q == TX_DATA) && ser_done && !sending_chk_q && (byte_idx_q != 2'd3);
  assign load_chk      = word_boundary && (send_left_q == '0);
  assign end_go        = (state_q == TX_DATA) && ser_done && sending_chk_q;
  assign ser_load      = load_word || next_byte || load_chk;
  assign ser_byte      = load_word ? byte_of(stage_q, 2'd0) :
                         next_byte ? byte_of(cur_q, byte_idx_q + 2'd1) : chk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q       <= TX_IDLE;
      stage_q       <= '0;
      cur_q         <= '0;
      stage_full_q  <= 1'b0;
      wait_word_q   <= 1'b0;
      sending_chk_q <= 1'b0;
      acc_left_q    <= '0;
      send_left_q   <= '0;
      byte_idx_q    <= '0;
      chk_q         <= '0;
    end else begin
      if (pkt_open) begin
        state_q       <= TX_START;
        stage_q       <= word_data_i;
        stage_full_q  <= 1'b1;
        acc_left_q    <= len_m1_i;
        send_left_q   <= len_m1_i;
        chk_q         <= '0;
        sending_chk_q <= 1'b0;
        wait_word_q   <= 1'b0;
      end else if (word_fire) begin
        stage_q      <= word_data_i;
        stage_full_q <= 1'b1;
        acc_left_q   <= acc_left_q - 1'b1;
      end
      if (load_word) begin
        cur_q        <= stage_q;
        stage_full_q <= 1'b0;
        byte_idx_q   <= '0;
        wait_word_q  <= 1'b0;
        if (state_q == TX_DATA) send_left_q <= send_left_q - 1'b1;
      end else if (need_word) begin
        wait_word_q <= 1'b1;
      end
      if (next_byte) byte_idx_q <= byte_idx_q + 2'd1;
      if (load_word || next_byte) chk_q <= chk_q ^ ser_byte;
      if (load_chk) sending_chk_q <= 1'b1;
      if (start_done) state_q <= TX_DATA;
      if (end_go) state_q <= TX_END;
      if ((state_q == TX_END) && pat_last) state_q <= TX_IDLE;
    end
  end

  alt_phase_pattern #(.UNIT_CYC(UNIT_CYC)) u_pattern (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .go_i      (pkt_open || end_go),
    .sel_end_i (end_go),
    .keep_a_i  (ser_a),
    .active_o  (pat_active),
    .last_o    (pat_last),
    .a_o       (pat_a),
    .b_o       (pat_b)
  );

  alt_phase_shift #(.PHASE_CYC(PHASE_CYC)) u_shift (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (ser_load),
    .byte_i   (ser_byte),
    .active_o (ser_active),
    .done_o   (ser_done),
    .a_o      (ser_a),
    .b_o      (ser_b)
  );

  assign busy_o      = (state_q != TX_IDLE);
  assign wire_a_oe_o = busy_o;
  assign wire_b_oe_o = busy_o;
  assign wire_a_o    = (state_q == TX_DATA) ? ser_a : pat_a;
  assign wire_b_o    = (state_q == TX_DATA) ? ser_b : pat_b;

  AST_ONE_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({pat_active, ser_active})); // R3
  AST_START_HANDOFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_done |-> (pat_a && !pat_b)); // R2
  AST_END_AFTER_CHECK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == TX_END) && ($past(state_q) == TX_DATA)) |-> $past(sending_chk_q)); // R5
  AST_RELEASE_AFTER_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> ($past(state_q) == TX_END)); // R7

endmodule

// File: tb/alt_phase_tx_tb_top.sv
module alt_phase_tx_tb_top;
  localparam int U = 125;
  localparam int H = U / 2;
  localparam int P = 8;
  localparam int S = P / 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vld = 1'b0;
  logic [31:0] dat = '0;
  logic [7:0] lenm1 = '0;
  logic rdy, busy, wa, wa_oe, wb, wb_oe;

  always #2 clk = ~clk;

  alt_phase_tx #(.LEN_W(8), .UNIT_CYC(U), .PHASE_CYC(P)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .word_valid_i(vld), .word_data_i(dat),
    .len_m1_i(lenm1), .word_ready_o(rdy), .busy_o(busy),
    .wire_a_o(wa), .wire_a_oe_o(wa_oe), .wire_b_o(wb), .wire_b_oe_o(wb_oe));

  typedef struct { logic a; logic b; string tag; } exp_t;
  exp_t q[$];
  int checks = 0, errors = 0, cyc = 0, hs_cyc = 0;
  bit in_pkt = 0, pkt_bad = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input string act, input string exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %s expected %s (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic push(input logic a, input logic b, input int n, input string tag);
    for (int i = 0; i < n; i++) q.push_back('{a: a, b: b, tag: tag});
  endtask

  task automatic push_byte(input logic [7:0] v, input string tag, inout int nbit, inout logic la);
    for (int i = 7; i >= 0; i--) begin
      logic d;
      d = v[i];
      if (nbit % 2 == 0) begin
        push(1'b1, d, S, tag); push(1'b0, d, P - S, tag);
      end else begin
        push(d, 1'b1, S, tag); push(d, 1'b0, P - S, tag);
        la = d;
      end
      nbit++;
    end
  endtask

  // driver: builds expected waveform, then feeds the words
  task automatic send_packet(input logic [31:0] w[8], input int n);
    int nbit = 0;
    logic la = 1'b1;
    logic [7:0] x = 8'h00;
    push(1, 1, U, "R2"); push(0, 1, U, "R2");
    for (int k = 0; k < 4; k++) begin push(0, 0, U, "R2"); push(0, 1, U, "R2"); end
    push(1, 1, 1, "R2"); push(1, 0, U, "R2");
    for (int j = 0; j < n; j++)
      for (int k = 0; k < 4; k++) begin
        push_byte(w[j][8*k +: 8], "R3/R4/R9", nbit, la);
        x = x ^ w[j][8*k +: 8];
      end
    push_byte(x, "R5", nbit, la);
    push(la, 1, H, "R6"); push(la, 0, H, "R6");
    push(0, 0, U, "R6"); push(1, 0, U, "R6"); push(0, 0, U, "R6");
    push(1, 0, U, "R6"); push(1, 1, U, "R6");
    for (int j = 0; j < n; j++) begin
      @(negedge clk);
      vld = 1'b1; dat = w[j]; lenm1 = 8'(n - 1);
      while (!rdy) @(negedge clk);
      if (j == 0) hs_cyc = cyc + 1;
    end
    // junk offered after all words: must be ignored (R8)
    @(negedge clk);
    dat = 32'hDEAD_BEEF; lenm1 = 8'd3;
    while (busy) begin
      check(!rdy, "R8", $sformatf("ready=%0b", rdy), "ready=0");
      @(negedge clk);
    end
    vld = 1'b0;
    for (int i = 0; i < 16; i++) begin
      check(!busy && !wa_oe && !wb_oe && rdy && q.size() == 0, "R8",
            $sformatf("busy=%0b oe=%0b%0b rdy=%0b", busy, wa_oe, wb_oe, rdy), "busy=0 oe=00 rdy=1");
      @(negedge clk);
    end
  endtask

  // monitor: compares every enabled cycle with the expected queue
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && wa_oe && !in_pkt) begin
        in_pkt = 1; pkt_bad = 0;
        check(cyc == hs_cyc, "R7", $sformatf("oe rise cycle %0d", cyc), $sformatf("%0d", hs_cyc));
      end
      if (in_pkt) begin
        if (q.size() == 0) begin
          check(!wa_oe && !wb_oe && !busy, "R7",
                $sformatf("oe=%0b%0b busy=%0b", wa_oe, wb_oe, busy), "oe=00 busy=0");
          in_pkt = 0;
        end else begin
          exp_t e;
          e = q.pop_front();
          if (!pkt_bad) begin
            logic [4:0] got, want;
            got  = {wa_oe, wb_oe, busy, wa, wb};
            want = {1'b1, 1'b1, 1'b1, e.a, e.b};
            check(got == want, e.tag, $sformatf("oe/busy/A/B=%b", got), $sformatf("%b", want));
            if (got != want) pkt_bad = 1;
          end
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] w[8];
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !wa_oe && !wb_oe && rdy, "R1",
          $sformatf("busy=%0b oe=%0b%0b rdy=%0b", busy, wa_oe, wb_oe, rdy), "busy=0 oe=00 rdy=1");
    foreach (w[i]) w[i] = '0;
    w[0] = 32'h1234_5678;
    send_packet(w, 1);                       // R9 single word
    w[0] = 32'hA5A5_0F0F; w[1] = 32'h0000_0000; w[2] = 32'hFFFF_FFFF;
    send_packet(w, 3);
    w[0] = 32'h8000_0001; w[1] = 32'h0102_0408; w[2] = 32'hC3C3_3C3C;
    w[3] = 32'h7F00_FF80; w[4] = 32'h5555_AAAA;
    send_packet(w, 5);
    w[0] = 32'h0000_0000;
    send_packet(w, 1);                       // R5 zero check byte, R6 k=0
    w[0] = 32'h0000_0100;
    send_packet(w, 1);                       // R6 k=1 (check byte 0x01)
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule